// File: doc/BRIEF.md
# Filter Output Rounding, Windowing and Clamping Stage

This block turns the wide signed accumulator results of two filter lanes into 16-bit two's complement output words. Each accepted sample is processed in three steps. First a rounding constant is added to the accumulator value at full precision. The sum is then shifted right by a programmable amount to pick a 16-bit window. Finally the value is clamped between a programmable lower bound and upper bound. Lane A and lane B each have their own banks of sixteen rounding constants, sixteen window positions and sixteen bound pairs. Every sample carries its own index into each bank, so the rounding point, the window and the limits can change from one output to the next.

In dual mode both lanes are active. Lane A drives a 16-bit port. Lane B's word is split across two ports: a 12-bit low part and a 4-bit high part. In single mode only lane A is used: it produces the combined filter output from lane A's banks, and both lane B ports stay at zero. The contents of the banks are supplied as static inputs; loading them is handled elsewhere.

Samples enter and leave through a valid/ready stream. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the result stays on the outputs unchanged, the whole pipeline holds, and `in_ready` is low. `in_valid` may be raised without waiting for `in_ready`. The source must hold a sample and its indices until that sample is taken.

Top module: `pix_out_shaper`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and all three data outputs are 0.
- R2: The rounding constant chosen by the lane's round index is a signed ACC_W-bit value. It is added to the signed accumulator input with one extra bit of precision, so the sum never wraps.
- R3: The rounded sum is arithmetically shifted right by the unsigned value in the window register chosen by the lane's window index. Any value above ACC_W-OUT_W acts as a shift of ACC_W-OUT_W.
- R4: A shifted value above 32767 becomes 32767, and one below -32768 becomes -32768. The window saturates and never wraps.
- R5: A limit register holds the signed upper bound in bits [31:16] and the signed lower bound in bits [15:0]. A value greater than the upper bound outputs the upper bound. Otherwise, a value less than the lower bound outputs the lower bound. The upper test wins when the bounds are reversed.
- R6: In dual mode (`dual_mode`=1, sampled with the input), lane B uses its own banks, indices and accumulator. Bits [11:0] of its word appear on `dout_b_lo` and bits [15:12] on `dout_b_hi`.
- R7: In single mode (`dual_mode`=0), `dout_a` carries the result from lane A's banks. `dout_b_lo` and `dout_b_hi` are 0 for that sample, whatever `acc_b` and the lane B indices are.
- R8: With `out_ready` held high, a sample taken at clock edge k shows up with `out_valid` high after edge k+2. `out_valid` never rises without a sample taken two edges earlier.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all outputs hold. Every taken sample is delivered exactly once and in order.
- R10: The round, window and limit indices of each lane choose entries independently. All sixteen entries of each bank can be reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1 = two independent lanes, 0 = lane A only; travels with the sample |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| acc_a | input | ACC_W | Lane A accumulator result, signed |
| acc_b | input | ACC_W | Lane B accumulator result, signed |
| a_rnd_idx | input | IDX_W | Lane A rounding constant index |
| a_win_idx | input | IDX_W | Lane A window register index |
| a_lim_idx | input | IDX_W | Lane A limit register index |
| b_rnd_idx | input | IDX_W | Lane B rounding constant index |
| b_win_idx | input | IDX_W | Lane B window register index |
| b_lim_idx | input | IDX_W | Lane B limit register index |
| rnd_bank_a | input | NREG*ACC_W | Lane A rounding constants, entry i at [i*ACC_W +: ACC_W] |
| rnd_bank_b | input | NREG*ACC_W | Lane B rounding constants |
| win_bank_a | input | NREG*SH_W | Lane A shift amounts, entry i at [i*SH_W +: SH_W] |
| win_bank_b | input | NREG*SH_W | Lane B shift amounts |
| lim_bank_a | input | NREG*2*OUT_W | Lane A bound pairs, entry i at [i*2*OUT_W +: 2*OUT_W] |
| lim_bank_b | input | NREG*2*OUT_W | Lane B bound pairs |
| out_valid | output | 1 | Output words valid |
| out_ready | input | 1 | Consumer takes the output words |
| dout_a | output | OUT_W | Lane A (or combined) result |
| dout_b_lo | output | LO_W | Lane B result, low bits |
| dout_b_hi | output | OUT_W-LO_W | Lane B result, high bits |

## Verification
The bench builds the block with ACC_W=24 and the default 16-bit output, 16-entry banks and 12/4 split. With these values the legal shift range is 0 to 8 and the 4-bit window codes run up to 15, so the codes 9 to 15 test the shift cap directly. At this size a sweep covers every combination of round, window and limit index on both lanes, with patterned and pseudo-random accumulator values. The bench first checks the latency with the output always ready, then applies random back-pressure and input gaps to test ordering and the hold behaviour.

// File: rtl/pos_pkg.sv
package pos_pkg;
  localparam int NUM_LANES = 2;
  localparam int LANE_A    = 0;
  localparam int LANE_B    = 1;
endpackage

// File: rtl/orsl_round_stage.sv
module orsl_round_stage #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16,
  parameter int NREG  = 16,
  parameter int SH_W  = 5,
  parameter int IDX_W = 4,
  localparam int SUM_W  = ACC_W + 1,
  localparam int MAX_SH = ACC_W - OUT_W,
  localparam int LIM_W  = 2 * OUT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    blank_in,
  input  logic [ACC_W-1:0]        acc,
  input  logic [IDX_W-1:0]        rnd_idx,
  input  logic [IDX_W-1:0]        win_idx,
  input  logic [IDX_W-1:0]        lim_idx,
  input  logic [NREG*ACC_W-1:0]   rnd_bank,
  input  logic [NREG*SH_W-1:0]    win_bank,
  input  logic [NREG*LIM_W-1:0]   lim_bank,
  output logic signed [SUM_W-1:0] sum_q,
  output logic [SH_W-1:0]         sh_q,
  output logic [LIM_W-1:0]        lim_q,
  output logic                    blank_q
);
  logic [ACC_W-1:0]        rnd_sel;
  logic [SH_W-1:0]         win_sel;
  logic [SH_W-1:0]         sh_d;
  logic signed [SUM_W-1:0] sum_d;

  always_comb begin
    rnd_sel = rnd_bank[rnd_idx*ACC_W +: ACC_W];
    win_sel = win_bank[win_idx*SH_W +: SH_W];
    // one guard bit keeps the rounding add exact
    sum_d   = $signed({acc[ACC_W-1], acc}) + $signed({rnd_sel[ACC_W-1], rnd_sel});
    sh_d    = (win_sel > SH_W'(MAX_SH)) ? SH_W'(MAX_SH) : win_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      sh_q    <= '0;
      lim_q   <= '0;
      blank_q <= 1'b0;
    end else if (en) begin
      sum_q   <= sum_d;
      sh_q    <= sh_d;
      lim_q   <= lim_bank[lim_idx*LIM_W +: LIM_W];
      blank_q <= blank_in;
    end
  end
endmodule

// File: rtl/orsl_window_clamp.sv
module orsl_window_clamp #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5,
  localparam int SUM_W = ACC_W + 1,
  localparam int LIM_W = 2 * OUT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [SUM_W-1:0] sum,
  input  logic [SH_W-1:0]         sh,
  input  logic [LIM_W-1:0]        lim,
  input  logic                    blank,
  output logic [OUT_W-1:0]        res_q
);
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'd1 << (OUT_W - 1)) - 64'd1);
  localparam logic signed [SUM_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [SUM_W-1:0] shifted;
  logic signed [OUT_W-1:0] win;
  logic signed [OUT_W-1:0] lim_hi;
  logic signed [OUT_W-1:0] lim_lo;
  logic signed [OUT_W-1:0] res_d;

  always_comb begin
    shifted = sum >>> sh;
    if (shifted > SAT_HI)
      win = {1'b0, {(OUT_W-1){1'b1}}};
    else if (shifted < SAT_LO)
      win = {1'b1, {(OUT_W-1){1'b0}}};
    else
      win = shifted[OUT_W-1:0];

    lim_hi = lim[LIM_W-1:OUT_W];
    lim_lo = lim[OUT_W-1:0];
    if (win > lim_hi)
      res_d = lim_hi;
    else if (win < lim_lo)
      res_d = lim_lo;
    else
      res_d = win;

    if (blank)
      res_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      res_q <= '0;
    else if (en)
      res_q <= res_d;
  end
endmodule

// File: rtl/orsl_lane.sv
module orsl_lane #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16,
  parameter int NREG  = 16,
  parameter int SH_W  = 5,
  parameter int IDX_W = 4,
  localparam int SUM_W = ACC_W + 1,
  localparam int LIM_W = 2 * OUT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en1,
  input  logic                  en2,
  input  logic                  blank_in,
  input  logic [ACC_W-1:0]      acc,
  input  logic [IDX_W-1:0]      rnd_idx,
  input  logic [IDX_W-1:0]      win_idx,
  input  logic [IDX_W-1:0]      lim_idx,
  input  logic [NREG*ACC_W-1:0] rnd_bank,
  input  logic [NREG*SH_W-1:0]  win_bank,
  input  logic [NREG*LIM_W-1:0] lim_bank,
  output logic [OUT_W-1:0]      res
);
  logic signed [SUM_W-1:0] sum_s1;
  logic [SH_W-1:0]         sh_s1;
  logic [LIM_W-1:0]        lim_s1;
  logic                    blank_s1;

  orsl_round_stage #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .NREG(NREG), .SH_W(SH_W), .IDX_W(IDX_W)
  ) u_round (
    .clk(clk), .rst_n(rst_n), .en(en1), .blank_in(blank_in), .acc(acc),
    .rnd_idx(rnd_idx), .win_idx(win_idx), .lim_idx(lim_idx),
    .rnd_bank(rnd_bank), .win_bank(win_bank), .lim_bank(lim_bank),
    .sum_q(sum_s1), .sh_q(sh_s1), .lim_q(lim_s1), .blank_q(blank_s1)
  );

  orsl_window_clamp #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)
  ) u_clamp (
    .clk(clk), .rst_n(rst_n), .en(en2), .sum(sum_s1), .sh(sh_s1),
    .lim(lim_s1), .blank(blank_s1), .res_q(res)
  );
endmodule

// File: rtl/pix_out_shaper.sv
module pix_out_shaper
  import pos_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16,
  parameter int NREG  = 16,
  parameter int LO_W  = 12,
  localparam int SH_W  = $clog2(ACC_W - OUT_W + 1),
  localparam int IDX_W = $clog2(NREG),
  localparam int LIM_W = 2 * OUT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dual_mode,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [ACC_W-1:0]      acc_a,
  input  logic [ACC_W-1:0]      acc_b,
  input  logic [IDX_W-1:0]      a_rnd_idx,
  input  logic [IDX_W-1:0]      a_win_idx,
  input  logic [IDX_W-1:0]      a_lim_idx,
  input  logic [IDX_W-1:0]      b_rnd_idx,
  input  logic [IDX_W-1:0]      b_win_idx,
  input  logic [IDX_W-1:0]      b_lim_idx,
  input  logic [NREG*ACC_W-1:0] rnd_bank_a,
  input  logic [NREG*ACC_W-1:0] rnd_bank_b,
  input  logic [NREG*SH_W-1:0]  win_bank_a,
  input  logic [NREG*SH_W-1:0]  win_bank_b,
  input  logic [NREG*LIM_W-1:0] lim_bank_a,
  input  logic [NREG*LIM_W-1:0] lim_bank_b,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [OUT_W-1:0]      dout_a,
  output logic [LO_W-1:0]       dout_b_lo,
  output logic [OUT_W-LO_W-1:0] dout_b_hi
);
  logic advance, s1_v, s2_v, s1_en, s2_en;

  // global stall: a waiting result freezes both stages
  assign advance   = !s2_v || out_ready;
  assign in_ready  = advance;
  assign out_valid = s2_v;
  assign s1_en     = advance && in_valid;
  assign s2_en     = advance && s1_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else if (advance) begin
      s1_v <= in_valid;
      s2_v <= s1_v;
    end
  end

  logic [ACC_W-1:0]      acc_l   [NUM_LANES];
  logic [IDX_W-1:0]      ridx_l  [NUM_LANES];
  logic [IDX_W-1:0]      widx_l  [NUM_LANES];
  logic [IDX_W-1:0]      lidx_l  [NUM_LANES];
  logic [NREG*ACC_W-1:0] rbank_l [NUM_LANES];
  logic [NREG*SH_W-1:0]  wbank_l [NUM_LANES];
  logic [NREG*LIM_W-1:0] lbank_l [NUM_LANES];
  logic                  blank_l [NUM_LANES];
  logic [OUT_W-1:0]      res_l   [NUM_LANES];

  assign acc_l[LANE_A]   = acc_a;
  assign acc_l[LANE_B]   = acc_b;
  assign ridx_l[LANE_A]  = a_rnd_idx;
  assign ridx_l[LANE_B]  = b_rnd_idx;
  assign widx_l[LANE_A]  = a_win_idx;
  assign widx_l[LANE_B]  = b_win_idx;
  assign lidx_l[LANE_A]  = a_lim_idx;
  assign lidx_l[LANE_B]  = b_lim_idx;
  assign rbank_l[LANE_A] = rnd_bank_a;
  assign rbank_l[LANE_B] = rnd_bank_b;
  assign wbank_l[LANE_A] = win_bank_a;
  assign wbank_l[LANE_B] = win_bank_b;
  assign lbank_l[LANE_A] = lim_bank_a;
  assign lbank_l[LANE_B] = lim_bank_b;
  assign blank_l[LANE_A] = 1'b0;
  assign blank_l[LANE_B] = !dual_mode;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    orsl_lane #(
      .ACC_W(ACC_W), .OUT_W(OUT_W), .NREG(NREG), .SH_W(SH_W), .IDX_W(IDX_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .en1(s1_en), .en2(s2_en),
      .blank_in(blank_l[g]), .acc(acc_l[g]),
      .rnd_idx(ridx_l[g]), .win_idx(widx_l[g]), .lim_idx(lidx_l[g]),
      .rnd_bank(rbank_l[g]), .win_bank(wbank_l[g]), .lim_bank(lbank_l[g]),
      .res(res_l[g])
    );
  end

  assign dout_a    = res_l[LANE_A];
  assign dout_b_lo = res_l[LANE_B][LO_W-1:0];
  assign dout_b_hi = res_l[LANE_B][OUT_W-1:LO_W];
endmodule

// File: rtl/pix_out_shaper_chk.sv
module pix_out_shaper_chk #(
  parameter int OUT_W = 16,
  parameter int LO_W  = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dual_mode,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [OUT_W-1:0]      dout_a,
  input logic [LO_W-1:0]       dout_b_lo,
  input logic [OUT_W-LO_W-1:0] dout_b_hi
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dout_a) &&
                                $stable(dout_b_lo) && $stable(dout_b_hi));

  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid);

  // R8
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  // R7
  single_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !dual_mode) ##1 in_ready |=>
      (dout_b_lo == '0 && dout_b_hi == '0));
endmodule

bind pix_out_shaper pix_out_shaper_chk #(.OUT_W(OUT_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .dout_a(dout_a), .dout_b_lo(dout_b_lo), .dout_b_hi(dout_b_hi)
);

// File: tb/pix_out_shaper_bench.sv
module pix_out_shaper_bench;
  localparam int AW = 24, OW = 16, NR = 16, LW = 12;
  localparam int SW = 4, IW = 4, LMW = 2 * OW, MAXSH = AW - OW;
  localparam int N_ITEMS = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dual_mode = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [AW-1:0] acc_a = '0, acc_b = '0;
  logic [IW-1:0] a_ri = '0, a_wi = '0, a_li = '0, b_ri = '0, b_wi = '0, b_li = '0;
  logic [NR*AW-1:0]  rbank_a, rbank_b;
  logic [NR*SW-1:0]  wbank_a, wbank_b;
  logic [NR*LMW-1:0] lbank_a, lbank_b;
  logic [OW-1:0]     dout_a;
  logic [LW-1:0]     dout_b_lo;
  logic [OW-LW-1:0]  dout_b_hi;

  logic [AW-1:0]  rnd_a [NR], rnd_b [NR];
  logic [SW-1:0]  win_a [NR], win_b [NR];
  logic [LMW-1:0] lim_a [NR], lim_b [NR];

  always #4 clk = ~clk;

  pix_out_shaper #(.ACC_W(AW), .OUT_W(OW), .NREG(NR), .LO_W(LW)) u_pix_out_shaper (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .in_valid(in_valid),
    .in_ready(in_ready), .acc_a(acc_a), .acc_b(acc_b),
    .a_rnd_idx(a_ri), .a_win_idx(a_wi), .a_lim_idx(a_li),
    .b_rnd_idx(b_ri), .b_win_idx(b_wi), .b_lim_idx(b_li),
    .rnd_bank_a(rbank_a), .rnd_bank_b(rbank_b),
    .win_bank_a(wbank_a), .win_bank_b(wbank_b),
    .lim_bank_a(lbank_a), .lim_bank_b(lbank_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .dout_a(dout_a), .dout_b_lo(dout_b_lo), .dout_b_hi(dout_b_hi)
  );

  int n_checks = 0, n_errs = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model built from R2..R5
  function automatic logic [15:0] model(input logic [AW-1:0] acc, input logic [AW-1:0] rnd,
                                       input logic [SW-1:0] shv, input logic [LMW-1:0] lim,
                                       output string tag);
    longint s, w, up, lo;
    int sh;
    s   = longint'($signed(acc)) + longint'($signed(rnd));
    sh  = (int'(shv) > MAXSH) ? MAXSH : int'(shv);
    tag = (int'(shv) > MAXSH) ? "R3" : "R2";
    w   = s >>> sh;
    if (w > 32767) begin w = 32767; tag = "R4"; end
    else if (w < -32768) begin w = -32768; tag = "R4"; end
    up = longint'($signed(lim[31:16]));
    lo = longint'($signed(lim[15:0]));
    if (w > up) begin w = up; tag = "R5"; end
    else if (w < lo) begin w = lo; tag = "R5"; end
    return w[15:0];
  endfunction

  function automatic logic [AW-1:0] pat(input int k);
    case (k)
      0: return 24'h7FFFFF;  1: return 24'h800000;  2: return 24'h000000;
      3: return 24'hFFFFFF;  4: return 24'h000001;  5: return 24'h007FFF;
      6: return 24'hFF8000;  7: return 24'h012345;  8: return 24'hFABCDF;
      9: return 24'h3FFFFF;  10: return 24'h000080; default: return 24'hFFFF81;
    endcase
  endfunction

  logic [31:0] lfsr = 32'h1234_5678;
  task automatic step_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  logic [15:0] qa[$], qb[$];
  string       qta[$], qtb[$];
  int          qcyc[$];
  bit          qlat[$];

  logic [15:0] pe_a, pe_b;
  string       pt_a, pt_b;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin : main
    int t, cyc, pops;
    bit pending, hold_prev, stall;
    logic [15:0] ha, hb;
    string tb_tag;
    for (int i = 0; i < NR; i++) begin
      rnd_a[i] = (i == 0) ? '0 : (i <= 9) ? AW'(1 << (i - 1)) : AW'(-(i * 37));
      win_a[i] = SW'(i);
      case (i)
        0: lim_a[i] = {16'h7FFF, 16'h8000};
        1: lim_a[i] = {16'h0100, 16'hFF00};
        2: lim_a[i] = {16'h0000, 16'h0000};
        3: lim_a[i] = {16'hFFF6, 16'h000A};
        default: lim_a[i] = {16'(i * 2000 - 8000), 16'(-(i * 1500))};
      endcase
    end
    for (int i = 0; i < NR; i++) begin
      rnd_b[i] = rnd_a[NR - 1 - i];
      win_b[i] = win_a[NR - 1 - i];
      lim_b[i] = lim_a[(i + 5) % NR];
      rbank_a[i*AW +: AW]   = rnd_a[i];
      rbank_b[i*AW +: AW]   = rnd_b[i];
      wbank_a[i*SW +: SW]   = win_a[i];
      wbank_b[i*SW +: SW]   = win_b[i];
      lbank_a[i*LMW +: LMW] = lim_a[i];
      lbank_b[i*LMW +: LMW] = lim_b[i];
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
    check(dout_a == '0, "R1 dout_a", 32'(dout_a), 0);
    check(dout_b_lo == '0 && dout_b_hi == '0, "R1 dout_b", {dout_b_hi, dout_b_lo}, 0);

    t = 0; cyc = 0; pops = 0; pending = 0; hold_prev = 0; ha = '0; hb = '0;
    while (!(t == N_ITEMS && qa.size() == 0)) begin
      @(negedge clk);
      cyc++;
      step_lfsr();
      stall = (t >= 1000) && (t < N_ITEMS);
      out_ready = stall ? lfsr[7] | lfsr[2] : 1'b1;
      if (!pending && t < N_ITEMS && (!stall || lfsr[11])) begin
        int k;
        // R10: every rnd/win/lim index combination on both lanes
        a_ri = IW'(t); a_wi = IW'(t >> 4); a_li = IW'(t >> 8);
        b_ri = a_wi;   b_wi = a_li;        b_li = a_ri;
        k = (t * 7 + (t >> 4)) % 12;
        acc_a = (t >= 4096) ? lfsr[23:0] : pat(k);
        acc_b = (t >= 4096) ? lfsr[31:8] : pat((k + 5) % 12);
        dual_mode = t[0] ^ t[4];
        pe_a = model(acc_a, rnd_a[a_ri], win_a[a_wi], lim_a[a_li], pt_a);
        pe_b = model(acc_b, rnd_b[b_ri], win_b[b_wi], lim_b[b_li], tb_tag);
        if (dual_mode) pt_b = {"R6 ", tb_tag};
        else begin pe_b = '0; pt_b = "R7"; end
        pending = 1;
      end
      in_valid = pending;
      #1;
      if (hold_prev) begin
        check(out_valid == 1'b1, "R9 valid held", 32'(out_valid), 1);
        check(dout_a == ha && {dout_b_hi, dout_b_lo} == hb, "R9 data held",
              {dout_a, dout_b_hi, dout_b_lo}, {ha, hb});
      end
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R9 in_ready low", 32'(in_ready), 0);
      hold_prev = out_valid && !out_ready;
      ha = dout_a;
      hb = {dout_b_hi, dout_b_lo};
      if (out_valid && out_ready) begin
        if (qa.size() == 0) begin
          check(1'b0, "R9 extra output", 32'(pops), 32'(t));
        end else begin
          logic [15:0] ea, eb;
          string tga, tgb;
          int pc;
          bit lat;
          ea = qa.pop_front(); eb = qb.pop_front();
          tga = qta.pop_front(); tgb = qtb.pop_front();
          pc = qcyc.pop_front(); lat = qlat.pop_front();
          check(dout_a == ea, tga, 32'(dout_a), 32'(ea));
          check(dout_b_lo == eb[11:0], {tgb, " low"}, 32'(dout_b_lo), 32'(eb[11:0]));
          check(dout_b_hi == eb[15:12], {tgb, " high"}, 32'(dout_b_hi), 32'(eb[15:12]));
          if (lat) check(cyc == pc + 2, "R8 latency", 32'(cyc - pc), 2);
          pops++;
        end
      end
      if (in_valid && in_ready) begin
        qa.push_back(pe_a); qb.push_back(pe_b);
        qta.push_back(pt_a); qtb.push_back(pt_b);
        qcyc.push_back(cyc); qlat.push_back(t < 990);
        pending = 0;
        t++;
      end
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R9: nothing lost or duplicated
    check(pops == N_ITEMS, "R9 delivered count", 32'(pops), 32'(N_ITEMS));
    check(out_valid == 1'b0, "R9 drained", 32'(out_valid), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule